// File: doc/BRIEF.md
# Interlace-Capable Raster Timing Generator

This block produces the pixel and line timing for a raster display. From a single pixel clock it counts pixels along each line and lines down each field. It drives a data-enable strobe, horizontal sync, vertical sync and a composite sync. Pixel 0 of line 0 is the top-left pixel of the active picture, so the active area comes first in every line and every field, and blanking and sync follow it.

In progressive mode every field is the same. In interlaced mode the block alternates between an even field and an odd field. All odd-field values are derived from the programmed set:
- the odd field is one line longer;
- its back porch (from the end of active video to the start of vertical sync) is one line longer;
- its vertical sync changes state half a line earlier within the line.

The front porch is the same in both fields, so the odd field's sync pulse ends one line later than the even field's. For a 1080i mode with a 2640-pixel line and horizontal sync starting at pixel 2448, the fields are 562 and 563 lines. The odd field's vertical sync changes at pixel 1128.

Software programs the timing through a write port that takes one 32-bit word per register. Each word holds two 16-bit halves, with the vertical value in the upper half. Writes land in a live copy. The copy that drives the counters is reloaded only as a new field begins. A one-cycle frame interrupt marks the end of each field's active picture, which leaves the blanking interval for loading the next field's values.

Top module: `ilace_timing_gen`

## Requirements
- R1: While reset is asserted, de_o, frame_irq_o and field_o are 0, and each sync output sits at its inactive level for the reset polarity. The first output cycle after reset is released shows pixel 0 of line 0 of an even field.
- R2: The write port decodes these addresses:
  - address 0 holds {active lines, active pixels};
  - address 1 holds {even-field total lines, total pixels per line};
  - address 2 holds {horizontal sync end pixel, horizontal sync start pixel};
  - address 3 holds {front porch lines, back porch lines};
  - address 4 is the mode word: bit 0 selects interlace, bit 1 inverts hsync, bit 2 inverts vsync, bit 3 inverts csync.

  For addresses 0 to 3 the first value listed sits in bits 31:16 and the second in bits 15:0. Writes to addresses 5 to 7 change nothing.
- R3: de_o is high exactly for pixels below the active pixel count on lines below the active line count. All outputs show a pixel one clock after its counter value, and all outputs for the same pixel appear together.
- R4: Horizontal sync is active for pixels p with start <= p < end on every line.
- R5: An even field, and every progressive field, lasts total lines. Its vertical sync is active in raster order from (active lines + back porch, hsync start pixel) up to, but not including, (total lines - front porch, hsync start pixel).
- R6: An odd field lasts total lines + 1. Its vertical sync starts at line active lines + back porch + 1 and ends at line total lines + 1 - front porch, so the front porch is unchanged. Both edges fall at pixel hsync start - floor(total pixels / 2).
- R7: After reset the first field is even. While the interlace bit read at a field boundary is 1, the field type toggles at that boundary. While the bit is 0, the next field is even.
- R8: Composite sync is the OR of active-high horizontal and vertical sync. Each of the three syncs is active high unless its mode invert bit is 1, in which case it is active low.
- R9: Values written during a field do not change that field. They take effect from the first pixel of the next field.
- R10: frame_irq_o is high for exactly one cycle, on the output cycle of the last pixel of the last active line. On that cycle field_o takes the type of the field being finished (0 even, 1 odd) and holds it until the next pulse.

Valid settings satisfy:
- sync start < sync end <= total pixels;
- hsync start >= total pixels / 2;
- a front porch of at least 1 line;
- active lines + back porch + 1 < total lines + 1 - front porch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register address |
| wr_data_i | input | 32 | Register write data, vertical half in 31:16 |
| de_o | output | 1 | Active-picture data enable |
| hsync_o | output | 1 | Horizontal sync, polarity per mode bit 1 |
| vsync_o | output | 1 | Vertical sync, polarity per mode bit 2 |
| csync_o | output | 1 | Composite sync, polarity per mode bit 3 |
| frame_irq_o | output | 1 | One-cycle pulse at the end of a field's active picture |
| field_o | output | 1 | Type of the field most recently finished (1 = odd) |

## Verification
The bound checker watches the following on every cycle:
- the interrupt stays a single-cycle pulse;
- field_o changes only on an interrupt cycle;
- the field type toggles at each boundary when interlace is on and drops to even when it is off;
- the working parameter set holds still between boundaries;
- the pixel and line counters stay inside the current field's totals.

The placement of each sync edge shows only in the bench's scenarios. The bench compares every output pixel by pixel against a reference raster built from the written settings. This covers the odd field's early vertical sync pixel, its extra line and longer back porch, and the polarity inversions. Field lengths measured between interrupts show that the double buffering works, that unused addresses are ignored, and that interlaced fields alternate.

// File: rtl/itg_pkg.sv
`timescale 1ns/1ps
package itg_pkg;
  localparam int HW = 16;
  localparam int AW = 3;
  localparam int DW = 2 * HW;

  localparam logic [AW-1:0] ADDR_ACT  = 3'd0;
  localparam logic [AW-1:0] ADDR_TOT  = 3'd1;
  localparam logic [AW-1:0] ADDR_HSY  = 3'd2;
  localparam logic [AW-1:0] ADDR_VPOR = 3'd3;
  localparam logic [AW-1:0] ADDR_MODE = 3'd4;

  typedef logic [HW-1:0] half_t;

  // Live register contents as written by software.
  typedef struct packed {
    half_t hact;
    half_t vact;
    half_t htot;
    half_t vtot;
    half_t hs_on;
    half_t hs_off;
    half_t vbp;
    half_t vfp;
    logic  ilace;
    logic  inv_h;
    logic  inv_v;
    logic  inv_c;
  } cfg_t;

  // Per-field working set, already resolved for even or odd.
  typedef struct packed {
    half_t hact;
    half_t vact;
    half_t htot;
    half_t vtot;
    half_t hs_on;
    half_t hs_off;
    half_t vs_on_ln;
    half_t vs_off_ln;
    half_t vs_px;
    logic  inv_h;
    logic  inv_v;
    logic  inv_c;
  } fset_t;

  function automatic fset_t derive(cfg_t c, logic odd);
    fset_t f;
    f.hact      = c.hact;
    f.vact      = c.vact;
    f.htot      = c.htot;
    f.vtot      = c.vtot + half_t'(odd);
    f.hs_on     = c.hs_on;
    f.hs_off    = c.hs_off;
    f.vs_on_ln  = c.vact + c.vbp + half_t'(odd);
    f.vs_off_ln = c.vtot + half_t'(odd) - c.vfp;
    f.vs_px     = odd ? (c.hs_on - (c.htot >> 1)) : c.hs_on;
    f.inv_h     = c.inv_h;
    f.inv_v     = c.inv_v;
    f.inv_c     = c.inv_c;
    return f;
  endfunction
endpackage

// File: rtl/itg_cfg_regs.sv
`timescale 1ns/1ps
module itg_cfg_regs
  import itg_pkg::*;
#(
  parameter cfg_t RST_CFG = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  output cfg_t          cfg_o
);
  cfg_t cfg_q;
  cfg_t cfg_d;

  always_comb begin
    cfg_d = cfg_q;
    if (wr_en) begin
      case (wr_addr)
        ADDR_ACT:  {cfg_d.vact, cfg_d.hact}     = wr_data;
        ADDR_TOT:  {cfg_d.vtot, cfg_d.htot}     = wr_data;
        ADDR_HSY:  {cfg_d.hs_off, cfg_d.hs_on}  = wr_data;
        ADDR_VPOR: {cfg_d.vfp, cfg_d.vbp}       = wr_data;
        ADDR_MODE: {cfg_d.inv_c, cfg_d.inv_v, cfg_d.inv_h, cfg_d.ilace} = wr_data[3:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= RST_CFG;
    else        cfg_q <= cfg_d;
  end

  assign cfg_o = cfg_q;
endmodule

// File: rtl/itg_raster.sv
`timescale 1ns/1ps
module itg_raster
  import itg_pkg::*;
#(
  parameter cfg_t RST_CFG = '0
) (
  input  logic  clk,
  input  logic  rst_n,
  input  cfg_t  cfg_i,
  output half_t pix_o,
  output half_t line_o,
  output logic  odd_o,
  output fset_t fset_o,
  output logic  field_end_o
);
  localparam fset_t RST_SET = derive(RST_CFG, 1'b0);

  half_t pix_q, pix_d;
  half_t line_q, line_d;
  logic  odd_q, odd_d;
  fset_t set_q, set_d;
  logic  line_end;
  logic  field_end;

  always_comb begin
    line_end  = (pix_q == set_q.htot - half_t'(1));
    field_end = line_end && (line_q == set_q.vtot - half_t'(1));
    pix_d     = line_end ? '0 : pix_q + half_t'(1);
    line_d    = line_q;
    odd_d     = odd_q;
    set_d     = set_q;
    if (field_end) begin
      line_d = '0;
      odd_d  = cfg_i.ilace & ~odd_q;
      set_d  = derive(cfg_i, cfg_i.ilace & ~odd_q);
    end else if (line_end) begin
      line_d = line_q + half_t'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pix_q  <= '0;
      line_q <= '0;
      odd_q  <= 1'b0;
      set_q  <= RST_SET;
    end else begin
      pix_q  <= pix_d;
      line_q <= line_d;
      odd_q  <= odd_d;
      set_q  <= set_d;
    end
  end

  assign pix_o       = pix_q;
  assign line_o      = line_q;
  assign odd_o       = odd_q;
  assign fset_o      = set_q;
  assign field_end_o = field_end;
endmodule

// File: rtl/itg_sync_out.sv
`timescale 1ns/1ps
module itg_sync_out
  import itg_pkg::*;
#(
  parameter logic [2:0] RST_INV = 3'b000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  half_t      pix,
  input  half_t      line,
  input  logic       odd,
  input  half_t      hact,
  input  half_t      vact,
  input  half_t      htot,
  input  half_t      hs_on,
  input  half_t      hs_off,
  input  half_t      vs_on_ln,
  input  half_t      vs_off_ln,
  input  half_t      vs_px,
  input  logic [2:0] inv,
  output logic       de_o,
  output logic [2:0] sync_o,
  output logic       irq_o,
  output logic       field_o
);
  localparam int NSYNC = 3;

  logic             de_d, de_q;
  logic             irq_d, irq_q;
  logic             fld_d, fld_q;
  logic             hs_raw, vs_raw;
  logic [NSYNC-1:0] raw;
  logic [NSYNC-1:0] sync_q;

  function automatic logic at_or_after(half_t ln, half_t px, half_t ref_ln, half_t ref_px);
    return (ln > ref_ln) || ((ln == ref_ln) && (px >= ref_px));
  endfunction

  always_comb begin
    de_d   = (pix < hact) && (line < vact);
    hs_raw = (pix >= hs_on) && (pix < hs_off);
    vs_raw = at_or_after(line, pix, vs_on_ln, vs_px) &&
             !at_or_after(line, pix, vs_off_ln, vs_px);
    raw    = {hs_raw | vs_raw, vs_raw, hs_raw};
    irq_d  = (line == vact - half_t'(1)) && (pix == htot - half_t'(1));
    fld_d  = irq_d ? odd : fld_q;
  end

  // One polarity stage per sync output: bit 0 h, bit 1 v, bit 2 composite.
  for (genvar g = 0; g < NSYNC; g++) begin : g_sync
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync_q[g] <= RST_INV[g];
      else        sync_q[g] <= raw[g] ^ inv[g];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      de_q  <= 1'b0;
      irq_q <= 1'b0;
      fld_q <= 1'b0;
    end else begin
      de_q  <= de_d;
      irq_q <= irq_d;
      fld_q <= fld_d;
    end
  end

  assign de_o    = de_q;
  assign sync_o  = sync_q;
  assign irq_o   = irq_q;
  assign field_o = fld_q;
endmodule

// File: rtl/ilace_timing_gen.sv
`timescale 1ns/1ps
module ilace_timing_gen
  import itg_pkg::*;
#(
  parameter int         DEF_HACT   = 12,
  parameter int         DEF_VACT   = 6,
  parameter int         DEF_HTOT   = 20,
  parameter int         DEF_VTOT   = 12,
  parameter int         DEF_HS_ON  = 14,
  parameter int         DEF_HS_OFF = 16,
  parameter int         DEF_VBP    = 2,
  parameter int         DEF_VFP    = 2,
  parameter logic       DEF_ILACE  = 1'b0,
  parameter logic [2:0] DEF_INV    = 3'b000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en_i,
  input  logic [2:0]    wr_addr_i,
  input  logic [31:0]   wr_data_i,
  output logic          de_o,
  output logic          hsync_o,
  output logic          vsync_o,
  output logic          csync_o,
  output logic          frame_irq_o,
  output logic          field_o
);
  localparam cfg_t RST_CFG = '{
    hact:   half_t'(DEF_HACT),
    vact:   half_t'(DEF_VACT),
    htot:   half_t'(DEF_HTOT),
    vtot:   half_t'(DEF_VTOT),
    hs_on:  half_t'(DEF_HS_ON),
    hs_off: half_t'(DEF_HS_OFF),
    vbp:    half_t'(DEF_VBP),
    vfp:    half_t'(DEF_VFP),
    ilace:  DEF_ILACE,
    inv_h:  DEF_INV[0],
    inv_v:  DEF_INV[1],
    inv_c:  DEF_INV[2]
  };

  cfg_t       cfg;
  half_t      pix;
  half_t      line;
  logic       odd;
  fset_t      fset;
  logic       field_end;
  logic [2:0] sync;

  itg_cfg_regs #(.RST_CFG(RST_CFG)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en_i),
    .wr_addr (wr_addr_i),
    .wr_data (wr_data_i),
    .cfg_o   (cfg)
  );

  itg_raster #(.RST_CFG(RST_CFG)) u_raster (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_i       (cfg),
    .pix_o       (pix),
    .line_o      (line),
    .odd_o       (odd),
    .fset_o      (fset),
    .field_end_o (field_end)
  );

  itg_sync_out #(.RST_INV(DEF_INV)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .pix       (pix),
    .line      (line),
    .odd       (odd),
    .hact      (fset.hact),
    .vact      (fset.vact),
    .htot      (fset.htot),
    .hs_on     (fset.hs_on),
    .hs_off    (fset.hs_off),
    .vs_on_ln  (fset.vs_on_ln),
    .vs_off_ln (fset.vs_off_ln),
    .vs_px     (fset.vs_px),
    .inv       ({fset.inv_c, fset.inv_v, fset.inv_h}),
    .de_o      (de_o),
    .sync_o    (sync),
    .irq_o     (frame_irq_o),
    .field_o   (field_o)
  );

  assign hsync_o = sync[0];
  assign vsync_o = sync[1];
  assign csync_o = sync[2];
endmodule

// File: rtl/itg_checker.sv
`timescale 1ns/1ps
module itg_checker
  import itg_pkg::*;
(
  input logic  clk,
  input logic  rst_n,
  input logic  frame_irq,
  input logic  field_id,
  input logic  field_end,
  input logic  ilace,
  input logic  odd,
  input half_t pix,
  input half_t line,
  input fset_t fset
);
  AST_IRQ_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    frame_irq |=> !frame_irq); // R10

  AST_FIELD_ID_ON_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(field_id) |-> frame_irq); // R10

  AST_PROGRESSIVE_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
    (field_end && !ilace) |=> !odd); // R7

  AST_INTERLACE_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (field_end && ilace) |=> (odd != $past(odd))); // R7

  AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !field_end |=> $stable(fset)); // R9

  AST_COUNTER_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (pix < fset.htot) && (line < fset.vtot)); // R5
endmodule

bind ilace_timing_gen itg_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .frame_irq (frame_irq_o),
  .field_id  (field_o),
  .field_end (field_end),
  .ilace     (cfg.ilace),
  .odd       (odd),
  .pix       (pix),
  .line      (line),
  .fset      (fset)
);

// File: tb/tb_ilace_timing_gen.sv
`timescale 1ns/1ps
module tb_ilace_timing_gen;
  localparam int D_HACT = 12, D_VACT = 6, D_HTOT = 20, D_VTOT = 12;
  localparam int D_HSON = 14, D_HSOFF = 16, D_VBP = 2, D_VFP = 2;
  localparam int WD_CYCLES = 190000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [2:0]  wr_addr;
  logic [31:0] wr_data;
  logic        de_o, hsync_o, vsync_o, csync_o, frame_irq_o, field_o;

  always #2.5 clk = ~clk;

  ilace_timing_gen #(
    .DEF_HACT(D_HACT), .DEF_VACT(D_VACT), .DEF_HTOT(D_HTOT), .DEF_VTOT(D_VTOT),
    .DEF_HS_ON(D_HSON), .DEF_HS_OFF(D_HSOFF), .DEF_VBP(D_VBP), .DEF_VFP(D_VFP),
    .DEF_ILACE(1'b0), .DEF_INV(3'b000)
  ) dut (
    .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .de_o(de_o), .hsync_o(hsync_o), .vsync_o(vsync_o),
    .csync_o(csync_o), .frame_irq_o(frame_irq_o), .field_o(field_o)
  );

  int nchk = 0;
  int nfail = 0;
  int cyc = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(string tag, logic act, logic exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s cycle=%0d actual=%0b expected=%0b", tag, cyc, act, exp);
    end
  endtask

  task automatic chk_int(string tag, int act, int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Reference raster built from what the bench has written.
  logic [15:0] m_hact, m_vact, m_htot, m_vtot, m_hson, m_hsoff, m_bp, m_fp;
  logic [3:0]  m_mode;
  logic [15:0] c_hact, c_vact, c_htot, c_vtot, c_hson, c_hsoff, c_vs0, c_vs1, c_vpx;
  logic [2:0]  c_inv;
  logic        c_odd;
  int          mpix, mline;
  logic        e_valid, e_de, e_hs, e_vs, e_cs, e_irq, e_field, e_odd;

  task automatic load_cur(logic odd);
    c_odd   = odd;
    c_hact  = m_hact;
    c_vact  = m_vact;
    c_htot  = m_htot;
    c_hson  = m_hson;
    c_hsoff = m_hsoff;
    c_vtot  = odd ? m_vtot + 16'd1 : m_vtot;
    c_vs0   = m_vact + m_bp + (odd ? 16'd1 : 16'd0);
    c_vs1   = c_vtot - m_fp;
    c_vpx   = odd ? m_hson - (m_htot / 16'd2) : m_hson;
    c_inv   = m_mode[3:1];
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_hact = 16'(D_HACT); m_vact = 16'(D_VACT); m_htot = 16'(D_HTOT); m_vtot = 16'(D_VTOT);
      m_hson = 16'(D_HSON); m_hsoff = 16'(D_HSOFF); m_bp = 16'(D_VBP); m_fp = 16'(D_VFP);
      m_mode = 4'b0000;
      load_cur(1'b0);
      mpix = 0; mline = 0;
      e_valid = 1'b0; e_field = 1'b0;
    end else begin
      int lin, s, e;
      logic h, v;
      lin = mline * int'(c_htot) + mpix;
      s   = int'(c_vs0) * int'(c_htot) + int'(c_vpx);
      e   = int'(c_vs1) * int'(c_htot) + int'(c_vpx);
      h   = (mpix >= int'(c_hson)) && (mpix < int'(c_hsoff));
      v   = (lin >= s) && (lin < e);
      e_de  = (mpix < int'(c_hact)) && (mline < int'(c_vact));
      e_hs  = h ^ c_inv[0];
      e_vs  = v ^ c_inv[1];
      e_cs  = (h | v) ^ c_inv[2];
      e_irq = (mline == int'(c_vact) - 1) && (mpix == int'(c_htot) - 1);
      e_odd = c_odd;
      if (e_irq) e_field = c_odd;
      e_valid = 1'b1;
      if (mpix == int'(c_htot) - 1) begin
        mpix = 0;
        if (mline == int'(c_vtot) - 1) begin
          mline = 0;
          load_cur(m_mode[0] & ~c_odd);
        end else begin
          mline++;
        end
      end else begin
        mpix++;
      end
      if (wr_en) begin
        case (wr_addr)
          3'd0: {m_vact, m_hact} = wr_data;
          3'd1: {m_vtot, m_htot} = wr_data;
          3'd2: {m_hsoff, m_hson} = wr_data;
          3'd3: {m_fp, m_bp} = wr_data;
          3'd4: m_mode = wr_data[3:0];
          default: ;
        endcase
      end
    end
  end

  bit run_done = 1'b0;

  always @(negedge clk) begin
    if (rst_n && e_valid && !run_done) begin
      chk("R3 de", de_o, e_de);
      chk("R4 hsync", hsync_o, e_hs);
      if (e_odd) chk("R6 odd-field vsync", vsync_o, e_vs);
      else       chk("R5 even-field vsync", vsync_o, e_vs);
      chk("R8 csync", csync_o, e_cs);
      chk("R10 frame irq", frame_irq_o, e_irq);
      chk("R10 field id", field_o, e_field);
    end
  end

  // Interrupt bookkeeping for field-length measurements.
  int   irq_cnt = 0;
  int   irq_last = 0;
  int   irq_prev = 0;
  logic irq_field = 1'b0;

  always @(negedge clk) begin
    if (rst_n && frame_irq_o) begin
      irq_prev  = irq_last;
      irq_last  = cyc;
      irq_field = field_o;
      irq_cnt++;
    end
  end

  task automatic wait_irqs(int n);
    int target;
    target = irq_cnt + n;
    while (irq_cnt < target) @(posedge clk);
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic run_all();
    repeat (3) @(negedge clk);
    chk("R1 reset de", de_o, 1'b0);
    chk("R1 reset hsync", hsync_o, 1'b0);
    chk("R1 reset vsync", vsync_o, 1'b0);
    chk("R1 reset csync", csync_o, 1'b0);
    chk("R1 reset irq", frame_irq_o, 1'b0);
    chk("R1 reset field", field_o, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 first pixel de", de_o, 1'b1);
    chk("R1 first pixel hsync", hsync_o, 1'b0);

    wait_irqs(2);
    chk_int("R5 progressive field length", irq_last - irq_prev, D_VTOT * D_HTOT);
    chk("R7 progressive field id", irq_field, 1'b0);

    wr(3'd5, 32'hFFFF_FFFF);
    wr(3'd6, 32'h0001_0001);
    wr(3'd7, 32'h0003_0002);
    wait_irqs(1);
    chk_int("R2 unused addresses ignored", irq_last - irq_prev, D_VTOT * D_HTOT);

    wr(3'd1, {16'd11, 16'd24});
    wr(3'd0, {16'd5, 16'd10});
    wr(3'd2, {16'd19, 16'd16});
    wr(3'd3, {16'd2, 16'd1});
    wait_irqs(1);
    chk_int("R9 current field unchanged", irq_last - irq_prev,
            (D_VTOT - D_VACT) * D_HTOT + 5 * 24);
    wait_irqs(1);
    chk_int("R9 new values applied", irq_last - irq_prev, 11 * 24);

    wr(3'd4, 32'h1);
    wait_irqs(1);
    chk_int("R6 field after enable", irq_last - irq_prev, 11 * 24);
    chk("R7 first interlaced field odd", irq_field, 1'b1);
    wait_irqs(1);
    chk_int("R6 odd field one line longer", irq_last - irq_prev, 12 * 24);
    chk("R7 alternation to even", irq_field, 1'b0);
    wait_irqs(1);
    chk_int("R5 even field length", irq_last - irq_prev, 11 * 24);
    chk("R7 alternation to odd", irq_field, 1'b1);

    wr(3'd4, 32'hF);
    wait_irqs(2);
    @(negedge clk);
    chk("R8 inverted hsync idle high", hsync_o, 1'b1);
    chk("R8 inverted vsync idle high", vsync_o, 1'b1);
    chk("R8 inverted csync idle high", csync_o, 1'b1);

    for (int k = 0; k < 20; k++) begin
      int ht, ha, hs0, hs1, va, bp, sw, fp, vt;
      ht  = 16 + int'($urandom % 25);
      ha  = 4 + int'($urandom % 32'(ht / 2 - 4));
      hs0 = ht / 2 + int'($urandom % 32'(ht / 2 - 2));
      hs1 = hs0 + 1 + int'($urandom % 32'(ht - 1 - hs0));
      va  = 3 + int'($urandom % 6);
      bp  = 1 + int'($urandom % 3);
      sw  = 1 + int'($urandom % 3);
      fp  = 1 + int'($urandom % 3);
      vt  = va + bp + sw + fp;
      wr(3'd1, {16'(vt), 16'(ht)});
      wr(3'd0, {16'(va), 16'(ha)});
      wr(3'd2, {16'(hs1), 16'(hs0)});
      wr(3'd3, {16'(fp), 16'(bp)});
      wr(3'd4, 32'($urandom % 16));
      wait_irqs(3);
    end
  endtask

  initial begin
    rst_n   = 1'b0;
    wr_en   = 1'b0;
    wr_addr = '0;
    wr_data = '0;
    void'($urandom(32'd7361));
    fork
      run_all();
      begin
        repeat (WD_CYCLES) @(posedge clk);
        nchk++;
        nfail++;
        $display("FAIL watchdog R1 actual=timeout expected=completion");
      end
    join_any
    run_done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule